// File: doc/BRIEF.md
# Virtually Tagged Read Cache Controller

This block governs a direct-mapped, virtually tagged data cache for a 32-bit processor. For every processor read it chooses between three outcomes: the read is served from a line already held in the cache, the read goes to memory as a single uncached word, or a whole line is fetched and installed. Tags, line data and per-line valid bits are kept inside the block. The address-translation buffer and the page-table walker sit outside. The block presents the address it is looking up, receives the translation hit and the page's no-fill flag in the same cycle, and asks for a walk through a request/done pair of pins.

Each line carries one valid bit for user mode and one for supervisor mode, so a line is invalid, valid for supervisor, or valid for user. Software purges one half of the cache by writing the matching translation root pointer, which raises a one-cycle strobe on this block. Which lines may be filled depends on where the address sits relative to a floor. That floor is 512 MiB with translation off and 16 MiB with translation on. With translation on, a per-page flag also blocks fills, but it never blocks hits.

The read request and read response are valid/ready streams. A request is accepted on a cycle where `req_valid` and `req_ready` are both high. A response stays on `rsp_valid` with `rsp_data` unchanged until `rsp_ready` is seen. Only one read is in flight at a time. The memory command port is valid/ready and the block holds `mem_addr` steady under back-pressure. Memory read data returns on `mem_rsp_valid`, which has no ready because the block always accepts it.

Top module: `vtag_cache`

## Requirements
- R1: `req_ready` is high only while no read is in flight. Once `rsp_valid` rises, it and `rsp_data` hold until a cycle with `rsp_ready` high, after which `req_ready` returns the next cycle.
- R2: With `mmu_en` low, the TLB inputs are ignored. A read whose line tag (address bits 31:12, line index bits 11:4) matches and whose valid bit for the request's privilege is set raises `rsp_valid` on the cycle after acceptance and makes no memory read.
- R3: With `mmu_en` low, a missing read below 0x2000_0000 makes one memory read at the word address (bits 1:0 zero) and leaves the cache unchanged. A missing read at or above 0x2000_0000 fills the line.
- R4: With `mmu_en` high, a read whose lookup sees `tlb_hit` low raises `walk_req` the next cycle and holds it until `walk_done`. The lookup is repeated on the cycle after `walk_done`; on a hit the response follows one cycle later.
- R5: With `mmu_en` high and `tlb_hit` high, a miss below 0x0100_0000 or with `tlb_ci` high makes a single-word uncached read. Any other miss fills the line.
- R6: `tlb_ci` high does not prevent a hit on a line that is already valid.
- R7: A fill issues four word reads at the line base plus offsets 0, 4, 8 and 12, in that order. It raises `rsp_valid` on the cycle after the fourth data word arrives, carrying the word selected by address bits 3:2, and later reads of that line return the filled words.
- R8: A fill sets the valid bit of the requesting privilege and clears the other privilege's bit for that line. A read hits only through the valid bit of its own privilege, so no line is ever valid for both.
- R9: A `user_root_wr` pulse clears every user valid bit by the next cycle and leaves every supervisor valid bit unchanged.
- R10: A `super_root_wr` pulse clears every supervisor valid bit by the next cycle and leaves every user valid bit unchanged.
- R11: A root-pointer strobe that arrives while a fill is in progress takes effect on the cycle the fill completes. The line just filled is then invalid if its privilege matches the cleared half and stays valid otherwise.
- R12: `mem_addr` stays stable while `mem_req_valid` is high and `mem_req_ready` is low. At most one memory read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request accepted |
| req_addr | input | 32 | Virtual byte address of the read |
| req_super | input | 1 | 1 = supervisor access, 0 = user access |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Processor takes the read data |
| rsp_data | output | 32 | Read data word |
| mmu_en | input | 1 | Address translation enabled |
| lk_addr | output | 32 | Address currently presented to the TLB |
| tlb_hit | input | 1 | TLB holds a translation for `lk_addr` |
| tlb_ci | input | 1 | Page of `lk_addr` is marked no-fill |
| walk_req | output | 1 | Table walk requested |
| walk_done | input | 1 | Table walk finished, one-cycle pulse |
| mem_req_valid | output | 1 | Memory word read command valid |
| mem_req_ready | input | 1 | Memory accepts the command |
| mem_addr | output | 32 | Word address of the memory read |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 32 | Memory read data |
| user_root_wr | input | 1 | User root pointer written, one-cycle pulse |
| super_root_wr | input | 1 | Supervisor root pointer written, one-cycle pulse |

## Verification
A hit is due on the cycle after acceptance, or two cycles after `walk_done` when a walk came first. An uncached read or a fill is due one cycle after the final memory data word. The bench records the cycle number of each acceptance, walk completion and memory data beat, and checks that `rsp_valid` first appears exactly on the predicted cycle and never earlier. A root-pointer strobe changes which lookups hit from the next cycle on, or from the end of a fill, so the bench observes it through the memory traffic and data of the read that follows. Memory addresses are compared against a queue predicted by a behavioural cache model on the cycle each command is accepted.

// File: rtl/vtag_pkg.sv
package vtag_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WALK,
    ST_LOOK,
    ST_MREQ,
    ST_MWAIT,
    ST_RESP
  } vtag_state_e;

  typedef enum logic [1:0] {
    ACT_HIT,
    ACT_WALK,
    ACT_BYPASS,
    ACT_FILL
  } vtag_act_e;
endpackage

// File: rtl/vtag_policy.sv
module vtag_policy #(
  parameter int AW = 32,
  parameter logic [AW-1:0] FLOOR_OFF = 32'h2000_0000,
  parameter logic [AW-1:0] FLOOR_ON  = 32'h0100_0000
) (
  input  logic [AW-1:0] addr,
  input  logic          mmu_en,
  input  logic          page_inhibit,
  output logic          may_fill
);
  // Fill permission only; hits are decided elsewhere and never gated here.
  assign may_fill = mmu_en ? ((addr >= FLOOR_ON) && !page_inhibit)
                           : (addr >= FLOOR_OFF);
endmodule

// File: rtl/vtag_valid.sv
module vtag_valid #(
  parameter  int LINES = 256,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             set_super,
  input  logic             clr_user,
  input  logic             clr_super,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_user,
  output logic             rd_super,
  output logic [LINES-1:0] user_vec,
  output logic [LINES-1:0] super_vec
);
  // One flop pair per line so a whole privilege half clears in one edge.
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic u_q, s_q, here;
    assign here = set_en && (set_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        u_q <= 1'b0;
        s_q <= 1'b0;
      end else if (here) begin
        u_q <= !set_super && !clr_user;
        s_q <= set_super && !clr_super;
      end else begin
        if (clr_user)  u_q <= 1'b0;
        if (clr_super) s_q <= 1'b0;
      end
    end
    assign user_vec[g]  = u_q;
    assign super_vec[g] = s_q;
  end

  assign rd_user  = user_vec[rd_idx];
  assign rd_super = super_vec[rd_idx];
endmodule

// File: rtl/vtag_store.sv
module vtag_store #(
  parameter  int LINES  = 256,
  parameter  int TAG_W  = 20,
  parameter  int LINE_W = 128,
  localparam int IDX_W  = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [TAG_W-1:0]  wtag,
  input  logic [LINE_W-1:0] wline,
  input  logic [IDX_W-1:0]  ridx,
  output logic [TAG_W-1:0]  rtag,
  output logic [LINE_W-1:0] rline
);
  logic [TAG_W-1:0]  tag_mem [LINES];
  logic [LINE_W-1:0] dat_mem [LINES];

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[widx] <= wtag;
      dat_mem[widx] <= wline;
    end
  end

  assign rtag  = tag_mem[ridx];
  assign rline = dat_mem[ridx];
endmodule

// File: rtl/vtag_ctrl.sv
module vtag_ctrl
  import vtag_pkg::*;
#(
  parameter  int AW     = 32,
  parameter  int DW     = 32,
  parameter  int WORDS  = 4,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int BYTE_W = $clog2(DW/8),
  localparam int OFF_W  = WSEL_W + BYTE_W,
  localparam int LINE_W = WORDS * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_super,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_data,
  input  logic              mmu_en,
  output logic [AW-1:0]     lk_addr,
  output logic              lk_super,
  input  logic              tlb_hit,
  input  logic              cache_hit,
  input  logic              may_fill,
  input  logic [LINE_W-1:0] rd_line,
  output logic              walk_req,
  input  logic              walk_done,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [DW-1:0]     mem_rsp_data,
  input  logic              user_root_wr,
  input  logic              super_root_wr,
  output logic              fill_we,
  output logic [LINE_W-1:0] fill_line,
  output logic              fill_super,
  output logic [AW-1:0]     fill_addr,
  output logic              clr_user,
  output logic              clr_super,
  output logic              fill_busy
);
  vtag_state_e       state;
  vtag_act_e         act;
  logic [AW-1:0]     addr_q;
  logic              super_q, fill_q, pend_u, pend_s, eval, last_word;
  logic [WSEL_W-1:0] wcnt;
  logic [LINE_W-1:0] line_buf;
  logic [DW-1:0]     rsp_q, hit_word;

  assign eval     = (state == ST_IDLE && req_valid) || (state == ST_LOOK);
  assign lk_addr  = (state == ST_IDLE) ? req_addr  : addr_q;
  assign lk_super = (state == ST_IDLE) ? req_super : super_q;
  assign hit_word = rd_line[lk_addr[OFF_W-1:BYTE_W]*DW +: DW];

  always_comb begin
    if (mmu_en && !tlb_hit) act = ACT_WALK;
    else if (cache_hit)     act = ACT_HIT;
    else if (may_fill)      act = ACT_FILL;
    else                    act = ACT_BYPASS;
  end

  assign last_word  = (wcnt == WSEL_W'(WORDS-1));
  assign fill_busy  = fill_q && (state == ST_MREQ || state == ST_MWAIT);
  assign fill_we    = fill_q && (state == ST_MWAIT) && mem_rsp_valid && last_word;
  assign fill_super = super_q;
  assign fill_addr  = addr_q;

  // Strobes during a fill wait for the fill's install cycle.
  assign clr_user  = (!fill_busy || fill_we) && (user_root_wr  || pend_u);
  assign clr_super = (!fill_busy || fill_we) && (super_root_wr || pend_s);

  always_comb begin
    fill_line = line_buf;
    fill_line[(WORDS-1)*DW +: DW] = mem_rsp_data;
  end

  assign req_ready     = (state == ST_IDLE);
  assign rsp_valid     = (state == ST_RESP);
  assign rsp_data      = rsp_q;
  assign walk_req      = (state == ST_WALK);
  assign mem_req_valid = (state == ST_MREQ);
  assign mem_addr      = fill_q ? {addr_q[AW-1:OFF_W], wcnt, {BYTE_W{1'b0}}}
                                : {addr_q[AW-1:BYTE_W], {BYTE_W{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      addr_q   <= '0;
      super_q  <= 1'b0;
      fill_q   <= 1'b0;
      wcnt     <= '0;
      line_buf <= '0;
      rsp_q    <= '0;
      pend_u   <= 1'b0;
      pend_s   <= 1'b0;
    end else begin
      pend_u <= fill_busy && !fill_we && (pend_u || user_root_wr);
      pend_s <= fill_busy && !fill_we && (pend_s || super_root_wr);
      case (state)
        ST_IDLE, ST_LOOK: begin
          if (eval) begin
            addr_q  <= lk_addr;
            super_q <= lk_super;
            wcnt    <= '0;
            case (act)
              ACT_HIT:  begin rsp_q <= hit_word; state <= ST_RESP; end
              ACT_WALK: state <= ST_WALK;
              ACT_FILL: begin fill_q <= 1'b1; state <= ST_MREQ; end
              default:  begin fill_q <= 1'b0; state <= ST_MREQ; end
            endcase
          end
        end
        ST_WALK: if (walk_done) state <= ST_LOOK;
        ST_MREQ: if (mem_req_ready) state <= ST_MWAIT;
        ST_MWAIT: begin
          if (mem_rsp_valid) begin
            if (!fill_q || wcnt == addr_q[OFF_W-1:BYTE_W]) rsp_q <= mem_rsp_data;
            if (fill_q) line_buf[wcnt*DW +: DW] <= mem_rsp_data;
            if (!fill_q || last_word) state <= ST_RESP;
            else begin
              wcnt  <= wcnt + 1'b1;
              state <= ST_MREQ;
            end
          end
        end
        ST_RESP: begin
          if (rsp_ready) begin
            state  <= ST_IDLE;
            fill_q <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vtag_cache.sv
module vtag_cache #(
  parameter  int AW    = 32,
  parameter  int DW    = 32,
  parameter  int LINES = 256,
  parameter  int WORDS = 4,
  parameter  logic [AW-1:0] FLOOR_OFF = 32'h2000_0000,
  parameter  logic [AW-1:0] FLOOR_ON  = 32'h0100_0000,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFF_W  = $clog2(WORDS) + $clog2(DW/8),
  localparam int TAG_W  = AW - IDX_W - OFF_W,
  localparam int LINE_W = WORDS * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_super,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  input  logic          mmu_en,
  output logic [AW-1:0] lk_addr,
  input  logic          tlb_hit,
  input  logic          tlb_ci,
  output logic          walk_req,
  input  logic          walk_done,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  input  logic          user_root_wr,
  input  logic          super_root_wr
);
  logic              lk_super, cache_hit, may_fill, rd_u, rd_s;
  logic              fill_we, fill_super, clr_user, clr_super, fill_busy;
  logic [AW-1:0]     fill_addr;
  logic [LINE_W-1:0] fill_line, rd_line;
  logic [TAG_W-1:0]  rd_tag;
  logic [LINES-1:0]  user_vec, super_vec;

  assign cache_hit = (rd_tag == lk_addr[AW-1 -: TAG_W]) && (lk_super ? rd_s : rd_u);

  vtag_ctrl #(.AW(AW), .DW(DW), .WORDS(WORDS)) u_ctrl (
    .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_super,
    .rsp_valid, .rsp_ready, .rsp_data, .mmu_en, .lk_addr, .lk_super,
    .tlb_hit, .cache_hit, .may_fill, .rd_line, .walk_req, .walk_done,
    .mem_req_valid, .mem_req_ready, .mem_addr, .mem_rsp_valid, .mem_rsp_data,
    .user_root_wr, .super_root_wr, .fill_we, .fill_line, .fill_super,
    .fill_addr, .clr_user, .clr_super, .fill_busy
  );

  vtag_policy #(.AW(AW), .FLOOR_OFF(FLOOR_OFF), .FLOOR_ON(FLOOR_ON)) u_policy (
    .addr(lk_addr), .mmu_en(mmu_en), .page_inhibit(tlb_ci), .may_fill(may_fill)
  );

  vtag_store #(.LINES(LINES), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
    .clk(clk), .we(fill_we), .widx(fill_addr[OFF_W +: IDX_W]),
    .wtag(fill_addr[AW-1 -: TAG_W]), .wline(fill_line),
    .ridx(lk_addr[OFF_W +: IDX_W]), .rtag(rd_tag), .rline(rd_line)
  );

  vtag_valid #(.LINES(LINES)) u_valid (
    .clk(clk), .rst_n(rst_n), .set_en(fill_we), .set_idx(fill_addr[OFF_W +: IDX_W]),
    .set_super(fill_super), .clr_user(clr_user), .clr_super(clr_super),
    .rd_idx(lk_addr[OFF_W +: IDX_W]), .rd_user(rd_u), .rd_super(rd_s),
    .user_vec(user_vec), .super_vec(super_vec)
  );
endmodule

// File: rtl/vtag_cache_chk.sv
module vtag_cache_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LINES = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [DW-1:0]    rsp_data,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [AW-1:0]    mem_addr,
  input logic             user_root_wr,
  input logic             super_root_wr,
  input logic             fill_busy,
  input logic [LINES-1:0] user_vec,
  input logic [LINES-1:0] super_vec
);
  // R1
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr));

  // R9
  user_purge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    user_root_wr && !fill_busy |=> $countones(user_vec) == 0);

  // R10
  super_purge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    super_root_wr && !fill_busy |=> $countones(super_vec) == 0);

  // R8
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(user_vec & super_vec) == 0);
endmodule

bind vtag_cache vtag_cache_chk #(.AW(AW), .DW(DW), .LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_addr(mem_addr), .user_root_wr(user_root_wr), .super_root_wr(super_root_wr),
  .fill_busy(fill_busy), .user_vec(user_vec), .super_vec(super_vec)
);

// File: tb/vtag_cache_test.sv
`timescale 1ns/1ps
module vtag_cache_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_super = 1'b0, rsp_ready = 1'b0, mmu_en = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready, rsp_valid, walk_req, mem_req_valid;
  logic [31:0] rsp_data, lk_addr, mem_addr;
  logic        tlb_hit, tlb_ci, walk_done = 1'b0;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        user_root_wr = 1'b0, super_root_wr = 1'b0;

  logic [19:0] tlb_page = '0;
  logic        tlb_vld = 1'b0, ci_on = 1'b0;
  assign tlb_hit = tlb_vld && (lk_addr[31:12] == tlb_page);
  assign tlb_ci  = ci_on;

  int nchk = 0, nfail = 0, cyc = 0, nwalk = 0, nhs = 0;
  int wdone_cyc = 0, last_rsp_cyc = 0;
  bit done = 1'b0;
  logic [15:0] gen = 16'h1;
  logic [31:0] expq[$];
  string cur_tag = "R7";

  logic [31:0] mdat [256][4];
  logic [19:0] mtag [256];
  bit          mu [256];
  bit          ms [256];

  vtag_cache uut (
    .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_super,
    .rsp_valid, .rsp_ready, .rsp_data, .mmu_en, .lk_addr, .tlb_hit, .tlb_ci,
    .walk_req, .walk_done, .mem_req_valid, .mem_req_ready, .mem_addr,
    .mem_rsp_valid, .mem_rsp_data, .user_root_wr, .super_root_wr
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] memval(logic [31:0] a);
    return a ^ {gen, gen};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Memory responder: one command at a time, data two cycles after accept.
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_req_ready = ((cyc % 3) != 1);
      #1;
      if (mem_req_valid && mem_req_ready) begin
        nhs++;
        if (expq.size() == 0) chk("R12 unexpected memory read", mem_addr, 32'hFFFF_FFFF);
        else chk({cur_tag, " memory address"}, mem_addr, expq.pop_front());
        @(negedge clk);
        mem_req_ready = 1'b0;
        @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = memval(mem_addr);
        last_rsp_cyc  = cyc;
      end
    end
  end

  // Table walker: loads the single-entry TLB model.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (walk_req) begin
        nwalk++;
        repeat (2) @(negedge clk);
        tlb_page  = lk_addr[31:12];
        tlb_vld   = 1'b1;
        walk_done = 1'b1;
        wdone_cyc = cyc;
        @(negedge clk);
        walk_done = 1'b0;
      end
    end
  end

  // Every-clock comparison of port-level invariants (R1, R12).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #3;
      chk("R12 walk and memory exclusive", {31'b0, walk_req && mem_req_valid}, 32'd0);
      chk("R1 ready while busy", {31'b0, rsp_valid && req_ready}, 32'd0);
    end
  end

  task automatic root(bit usr);
    @(negedge clk);
    if (usr) user_root_wr = 1'b1; else super_root_wr = 1'b1;
    @(negedge clk);
    user_root_wr  = 1'b0;
    super_root_wr = 1'b0;
  endtask

  task automatic model_clear(bit usr);
    for (int i = 0; i < 256; i++) begin
      if (usr) mu[i] = 1'b0; else ms[i] = 1'b0;
    end
  endtask

  task automatic do_req(logic [31:0] a, bit sup, int stall, string tag);
    int idx, w, nwords, acc, due, w0;
    bit hitm, walkx, cacheable;
    logic [31:0] exp_d, base;
    idx = int'(a[11:4]);
    w   = int'(a[3:2]);
    base = {a[31:4], 4'h0};
    walkx = mmu_en && !(tlb_vld && tlb_page == a[31:12]);
    hitm = (mtag[idx] == a[31:12]) && (sup ? ms[idx] : mu[idx]);
    nwords = 0;
    if (hitm) exp_d = mdat[idx][w];
    else begin
      cacheable = mmu_en ? (a >= 32'h0100_0000 && !ci_on) : (a >= 32'h2000_0000);
      exp_d = memval({a[31:2], 2'b00});
      if (cacheable) begin
        nwords = 4;
        for (int k = 0; k < 4; k++) begin
          expq.push_back(base + 32'(4 * k));
          mdat[idx][k] = memval(base + 32'(4 * k));
        end
        mtag[idx] = a[31:12];
        mu[idx] = !sup;
        ms[idx] = sup;
      end else begin
        nwords = 1;
        expq.push_back({a[31:2], 2'b00});
      end
    end
    cur_tag = tag;
    w0 = nwalk;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_super = sup;
    acc = cyc;
    due = -1;
    for (int t = 0; t < 400; t++) begin
      @(negedge clk);
      req_valid = 1'b0;
      #2;
      if (rsp_valid) begin
        if (nwords != 0) due = last_rsp_cyc + 1;
        else due = walkx ? wdone_cyc + 2 : acc + 1;
        break;
      end
    end
    chk({tag, " response cycle"}, cyc, due);
    chk({tag, " response data"}, rsp_data, exp_d);
    chk({tag, " walk count"}, nwalk - w0, walkx ? 1 : 0);
    if (stall > 0) begin
      repeat (stall) @(negedge clk);
      #2;
      chk("R1 held response valid", {31'b0, rsp_valid}, 32'd1);
      chk("R1 held response data", rsp_data, exp_d);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    #2;
    chk("R1 response released", {31'b0, rsp_valid}, 32'd0);
    chk("R1 ready again", {31'b0, req_ready}, 32'd1);
    chk({tag, " memory reads done"}, expq.size(), 0);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int h0;
    for (int i = 0; i < 256; i++) begin mu[i] = 0; ms[i] = 0; mtag[i] = '1; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R1 reset req_ready", {31'b0, req_ready}, 32'd1);
    chk("R1 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R12 reset mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
    chk("R4 reset walk_req", {31'b0, walk_req}, 32'd0);

    // Translation off
    do_req(32'h4000_0018, 1'b0, 2, "R7");
    do_req(32'h4000_0018, 1'b0, 0, "R2");
    gen = 16'h2;
    do_req(32'h4000_0014, 1'b0, 1, "R2");
    do_req(32'h1000_0008, 1'b0, 0, "R3");
    do_req(32'h1000_0008, 1'b0, 0, "R3");
    do_req(32'h2000_0000, 1'b1, 0, "R3");
    do_req(32'h4000_0010, 1'b1, 0, "R8");
    do_req(32'h4000_0010, 1'b0, 0, "R8");
    do_req(32'h5000_002C, 1'b1, 0, "R8");

    // Root pointer strobes while idle
    root(1'b1); model_clear(1'b1);
    do_req(32'h5000_0028, 1'b1, 0, "R9");
    do_req(32'h4000_0010, 1'b0, 0, "R9");
    root(1'b0); model_clear(1'b0);
    do_req(32'h5000_0028, 1'b1, 0, "R10");
    do_req(32'h4000_0014, 1'b0, 0, "R10");

    // Translation on
    mmu_en = 1'b1;
    do_req(32'h0800_0044, 1'b0, 0, "R4");
    do_req(32'h0800_0040, 1'b0, 0, "R4");
    do_req(32'h0080_0004, 1'b0, 0, "R5");
    ci_on = 1'b1;
    do_req(32'h0800_004C, 1'b0, 0, "R6");
    do_req(32'h0900_0000, 1'b1, 0, "R5");
    do_req(32'h0900_0000, 1'b1, 0, "R5");
    ci_on = 1'b0;

    // Strobes that land inside a fill
    h0 = nhs;
    fork
      do_req(32'h0A00_0030, 1'b0, 0, "R11");
      begin
        wait (nhs == h0 + 1);
        root(1'b1);
      end
    join
    model_clear(1'b1);
    do_req(32'h0A00_0030, 1'b0, 0, "R11");
    h0 = nhs;
    fork
      do_req(32'h0A00_0130, 1'b0, 0, "R11");
      begin
        wait (nhs == h0 + 1);
        root(1'b0);
      end
    join
    model_clear(1'b0);
    do_req(32'h0A00_0134, 1'b0, 0, "R11");

    mmu_en = 1'b0;
    do_req(32'h6000_0000, 1'b0, 3, "R12");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule